// File: doc/BRIEF.md
# DMA Channel Service Sequencer

This block sits between a DMA controller's register file and its memory port. When kicked, it walks the channels from the lowest index to the highest. It serves a channel only when that channel is unmasked and has its request bit set. For each channel it serves, it builds a physical byte address from a high page, a low page and a 16-bit offset. It then moves bytes one at a time over a request/acknowledge memory handshake until the programmed length has been covered.

The register file supplies the per-channel mask, request, mode, base count, base address, page and current-count values as flat vectors. After every byte, the sequencer writes the updated transferred count back through a single write port. When a channel completes, it pulses that channel's terminal-count bit. A kick that arrives while a channel is being served is remembered. Once the current channel has finished or been skipped, the scan restarts from channel 0.

Mode byte layout used by this block: bits [3:2] give the transfer type (00 verify, 01 write to memory, 10 read from memory, 11 treated like verify). Bit 4 selects auto-initialisation. Bit 5 selects a descending address.

Top module: `dma_svc_seq`

## Requirements
- R1: A channel is served only when its mask bit is 0 and its request bit is 1; any other channel produces no memory request, no count write-back and no terminal-count pulse.
- R2: Within one scan, eligible channels are served in ascending index order, each to completion before the next one starts.
- R3: A served channel performs exactly ((base count + 1) << WSHIFT) minus its starting count byte steps.
- R4: Reaching the full length pulses tc_o for one cycle, one-hot at the channel index, in the same cycle as the final count write-back.
- R5: mem_addr_o is {high page[6:0], low page[7:0], offset[15:0]}.
- R6: With mode bit 5 clear, the offset for byte n is (base address << WSHIFT) + n; with bit 5 set, it is (base address << WSHIFT) - n, modulo 2^16.
- R7: With mode bits [3:2] equal to 00 (or 11), the count advances one byte per cycle and mem_req_o stays low.
- R8: mem_wr_o is 1 for mode bits [3:2] = 01 (write to memory) and 0 for 10 (read from memory).
- R9: With mode bit 4 set, the write-back at terminal count carries 0 instead of the full length.
- R10: Each completed byte (mem_req_o and mem_ack_i both high at a clock edge, or one verify step) produces a cnt_we_o pulse in the next cycle. That pulse carries the channel in cnt_ch_o and the incremented count in cnt_val_o.
- R11: While mem_req_o is high and mem_ack_i is low, mem_req_o, mem_addr_o and mem_wr_o hold their values into the next cycle.
- R12: A kick_i pulse during service makes the scan restart at channel 0 once the current channel is finished or skipped.
- R13: An eligible channel whose current count already equals or exceeds its length gets a terminal-count pulse with no memory access.
- R14: After reset the block is idle: busy_o, mem_req_o, cnt_we_o and tc_o are all 0, and mem_req_o is never high while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick_i | input | 1 | Start a scan, or request a rescan while busy |
| mask_i | input | NCH | Per-channel mask, 1 = masked |
| req_i | input | NCH | Per-channel request |
| mode_i | input | NCH*8 | Per-channel mode bytes |
| base_cnt_i | input | NCH*CNT_W | Per-channel programmed count (length minus one) |
| base_addr_i | input | NCH*OFF_W | Per-channel base offset |
| hpage_i | input | NCH*HP_W | Per-channel high page |
| lpage_i | input | NCH*LP_W | Per-channel low page |
| cur_cnt_i | input | NCH*LEN_W | Per-channel bytes already transferred |
| mem_req_o | output | 1 | Memory access request |
| mem_addr_o | output | HP_W+LP_W+OFF_W | Physical byte address |
| mem_wr_o | output | 1 | 1 = write to memory, 0 = read |
| mem_ack_i | input | 1 | Memory access accepted |
| cnt_we_o | output | 1 | Count write-back strobe |
| cnt_ch_o | output | CH_W | Channel of the write-back |
| cnt_val_o | output | LEN_W | New transferred count |
| tc_o | output | NCH | One-cycle terminal-count pulse per channel |
| busy_o | output | 1 | Scan in progress |

## Verification
On every cycle, the assertions check the memory handshake hold rule and that a completed byte is always followed by a write-back. They also check that terminal-count pulses are one-hot and always coincide with a write-back, and that no request appears while the block is idle. Other behaviour depends on the programmed channel state, and only the bench's scenarios can show it. That includes address composition and direction, byte totals, auto-init reload, verify mode, channel order, ignoring masked or unrequested channels, and the rescan after a late kick.

// File: rtl/dma_svc_pkg.sv
package dma_svc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_XFER  = 2'd2,
        ST_NEXT  = 2'd3
    } seq_st_e;

    typedef enum logic [1:0] {
        XT_VERIFY  = 2'd0,
        XT_TOMEM   = 2'd1,
        XT_FROMMEM = 2'd2,
        XT_RSVD    = 2'd3
    } xfer_type_e;

    localparam int MODE_W     = 8;
    localparam int MB_TYPE_LO = 2;
    localparam int MB_AUTO    = 4;
    localparam int MB_DEC     = 5;

    function automatic logic touches_mem(input xfer_type_e t);
        return (t == XT_TOMEM) || (t == XT_FROMMEM);
    endfunction

endpackage

// File: rtl/dma_svc_chan_mux.sv
module dma_svc_chan_mux
    import dma_svc_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CH_W   = 2,
    parameter int CNT_W  = 16,
    parameter int OFF_W  = 16,
    parameter int HP_W   = 7,
    parameter int LP_W   = 8,
    parameter int LEN_W  = 17,
    parameter int WSHIFT = 0
) (
    input  logic [CH_W-1:0]        ch_i,
    input  logic [NCH-1:0]         mask_i,
    input  logic [NCH-1:0]         req_i,
    input  logic [NCH*MODE_W-1:0]  mode_i,
    input  logic [NCH*CNT_W-1:0]   base_cnt_i,
    input  logic [NCH*OFF_W-1:0]   base_addr_i,
    input  logic [NCH*HP_W-1:0]    hpage_i,
    input  logic [NCH*LP_W-1:0]    lpage_i,
    input  logic [NCH*LEN_W-1:0]   cur_cnt_i,
    output logic                   eligible_o,
    output logic [MODE_W-1:0]      mode_o,
    output logic [OFF_W-1:0]       base_addr_o,
    output logic [HP_W-1:0]        hpage_o,
    output logic [LP_W-1:0]        lpage_o,
    output logic [LEN_W-1:0]       cur_cnt_o,
    output logic [LEN_W-1:0]       len_o
);

    logic [MODE_W-1:0] mode_a  [NCH];
    logic [CNT_W-1:0]  bcnt_a  [NCH];
    logic [OFF_W-1:0]  badr_a  [NCH];
    logic [HP_W-1:0]   hp_a    [NCH];
    logic [LP_W-1:0]   lp_a    [NCH];
    logic [LEN_W-1:0]  cur_a   [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign mode_a[g] = mode_i[g*MODE_W +: MODE_W];
        assign bcnt_a[g] = base_cnt_i[g*CNT_W +: CNT_W];
        assign badr_a[g] = base_addr_i[g*OFF_W +: OFF_W];
        assign hp_a[g]   = hpage_i[g*HP_W +: HP_W];
        assign lp_a[g]   = lpage_i[g*LP_W +: LP_W];
        assign cur_a[g]  = cur_cnt_i[g*LEN_W +: LEN_W];
    end

    logic [LEN_W-1:0] bcnt_wide;

    assign eligible_o  = !mask_i[ch_i] && req_i[ch_i];
    assign mode_o      = mode_a[ch_i];
    assign base_addr_o = badr_a[ch_i];
    assign hpage_o     = hp_a[ch_i];
    assign lpage_o     = lp_a[ch_i];
    assign cur_cnt_o   = cur_a[ch_i];
    assign bcnt_wide   = LEN_W'(bcnt_a[ch_i]);
    assign len_o       = (bcnt_wide + LEN_W'(1)) << WSHIFT;

endmodule

// File: rtl/dma_svc_addr_gen.sv
module dma_svc_addr_gen #(
    parameter int OFF_W  = 16,
    parameter int HP_W   = 7,
    parameter int LP_W   = 8,
    parameter int LEN_W  = 17,
    parameter int WSHIFT = 0,
    localparam int PA_W  = HP_W + LP_W + OFF_W
) (
    input  logic [OFF_W-1:0] base_addr_i,
    input  logic [HP_W-1:0]  hpage_i,
    input  logic [LP_W-1:0]  lpage_i,
    input  logic [LEN_W-1:0] cnt_i,
    input  logic             dec_i,
    output logic [PA_W-1:0]  phys_o
);

    logic [OFF_W-1:0] start_off;
    logic [OFF_W-1:0] step_off;
    logic [OFF_W-1:0] off;

    assign start_off = base_addr_i << WSHIFT;
    assign step_off  = OFF_W'(cnt_i);
    assign off       = dec_i ? (start_off - step_off) : (start_off + step_off);
    assign phys_o    = {hpage_i, lpage_i, off};

endmodule

// File: rtl/dma_svc_seq.sv
module dma_svc_seq
    import dma_svc_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int OFF_W  = 16,
    parameter int HP_W   = 7,
    parameter int LP_W   = 8,
    parameter int WSHIFT = 0,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int LEN_W = CNT_W + 1 + WSHIFT,
    localparam int PA_W  = HP_W + LP_W + OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  kick_i,
    input  logic [NCH-1:0]        mask_i,
    input  logic [NCH-1:0]        req_i,
    input  logic [NCH*8-1:0]      mode_i,
    input  logic [NCH*CNT_W-1:0]  base_cnt_i,
    input  logic [NCH*OFF_W-1:0]  base_addr_i,
    input  logic [NCH*HP_W-1:0]   hpage_i,
    input  logic [NCH*LP_W-1:0]   lpage_i,
    input  logic [NCH*LEN_W-1:0]  cur_cnt_i,
    output logic                  mem_req_o,
    output logic [PA_W-1:0]       mem_addr_o,
    output logic                  mem_wr_o,
    input  logic                  mem_ack_i,
    output logic                  cnt_we_o,
    output logic [CH_W-1:0]       cnt_ch_o,
    output logic [LEN_W-1:0]      cnt_val_o,
    output logic [NCH-1:0]        tc_o,
    output logic                  busy_o
);

    typedef struct packed {
        seq_st_e           st;
        logic [CH_W-1:0]   ch;
        logic [LEN_W-1:0]  cnt;
        logic              kick_pend;
        logic              cnt_we;
        logic [LEN_W-1:0]  cnt_val;
        logic [NCH-1:0]    tc;
    } seq_regs_t;

    seq_regs_t q, d;

    // Selected channel view
    logic              sel_elig;
    logic [MODE_W-1:0] sel_mode;
    logic [OFF_W-1:0]  sel_badr;
    logic [HP_W-1:0]   sel_hp;
    logic [LP_W-1:0]   sel_lp;
    logic [LEN_W-1:0]  sel_cur;
    logic [LEN_W-1:0]  sel_len;
    xfer_type_e        sel_type;
    logic              sel_auto;
    logic              sel_dec;
    logic              sel_access;

    dma_svc_chan_mux #(
        .NCH(NCH), .CH_W(CH_W), .CNT_W(CNT_W), .OFF_W(OFF_W),
        .HP_W(HP_W), .LP_W(LP_W), .LEN_W(LEN_W), .WSHIFT(WSHIFT)
    ) u_mux (
        .ch_i        (q.ch),
        .mask_i      (mask_i),
        .req_i       (req_i),
        .mode_i      (mode_i),
        .base_cnt_i  (base_cnt_i),
        .base_addr_i (base_addr_i),
        .hpage_i     (hpage_i),
        .lpage_i     (lpage_i),
        .cur_cnt_i   (cur_cnt_i),
        .eligible_o  (sel_elig),
        .mode_o      (sel_mode),
        .base_addr_o (sel_badr),
        .hpage_o     (sel_hp),
        .lpage_o     (sel_lp),
        .cur_cnt_o   (sel_cur),
        .len_o       (sel_len)
    );

    assign sel_type   = xfer_type_e'(sel_mode[MB_TYPE_LO +: 2]);
    assign sel_auto   = sel_mode[MB_AUTO];
    assign sel_dec    = sel_mode[MB_DEC];
    assign sel_access = touches_mem(sel_type);

    dma_svc_addr_gen #(
        .OFF_W(OFF_W), .HP_W(HP_W), .LP_W(LP_W),
        .LEN_W(LEN_W), .WSHIFT(WSHIFT)
    ) u_addr (
        .base_addr_i (sel_badr),
        .hpage_i     (sel_hp),
        .lpage_i     (sel_lp),
        .cnt_i       (q.cnt),
        .dec_i       (sel_dec),
        .phys_o      (mem_addr_o)
    );

    // Next-state logic
    always_comb begin
        logic             step;
        logic [LEN_W-1:0] nxt_cnt;

        d          = q;
        d.cnt_we   = 1'b0;
        d.tc       = '0;
        step       = 1'b0;
        nxt_cnt    = q.cnt + LEN_W'(1);

        unique case (q.st)
            ST_IDLE: begin
                if (kick_i) begin
                    d.st        = ST_CHECK;
                    d.ch        = '0;
                    d.kick_pend = 1'b0;
                end
            end

            ST_CHECK: begin
                if (kick_i) d.kick_pend = 1'b1;
                if (sel_elig) begin
                    d.cnt = sel_cur;
                    if (sel_cur >= sel_len) begin
                        d.tc[q.ch] = 1'b1;
                        d.cnt_we   = 1'b1;
                        d.cnt_val  = sel_auto ? '0 : sel_cur;
                        d.st       = ST_NEXT;
                    end else begin
                        d.st = ST_XFER;
                    end
                end else begin
                    d.st = ST_NEXT;
                end
            end

            ST_XFER: begin
                if (kick_i) d.kick_pend = 1'b1;
                step = sel_access ? mem_ack_i : 1'b1;
                if (step) begin
                    d.cnt    = nxt_cnt;
                    d.cnt_we = 1'b1;
                    if (nxt_cnt >= sel_len) begin
                        d.tc[q.ch] = 1'b1;
                        d.cnt_val  = sel_auto ? '0 : nxt_cnt;
                        d.st       = ST_NEXT;
                    end else begin
                        d.cnt_val  = nxt_cnt;
                    end
                end
            end

            ST_NEXT: begin
                if (q.kick_pend || kick_i) begin
                    d.st        = ST_CHECK;
                    d.ch        = '0;
                    d.kick_pend = 1'b0;
                end else if (q.ch == CH_W'(NCH - 1)) begin
                    d.st = ST_IDLE;
                end else begin
                    d.st = ST_CHECK;
                    d.ch = q.ch + CH_W'(1);
                end
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ch: '0, cnt: '0, kick_pend: 1'b0,
                   cnt_we: 1'b0, cnt_val: '0, tc: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_req_o = (q.st == ST_XFER) && sel_access;
    assign mem_wr_o  = (sel_type == XT_TOMEM);
    assign cnt_we_o  = q.cnt_we;
    assign cnt_ch_o  = q.ch;
    assign cnt_val_o = q.cnt_val;
    assign tc_o      = q.tc;
    assign busy_o    = (q.st != ST_IDLE);

endmodule

// File: rtl/dma_svc_seq_chk.sv
module dma_svc_seq_chk #(
    parameter int NCH  = 4,
    parameter int PA_W = 31
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy_o,
    input logic            mem_req_o,
    input logic [PA_W-1:0] mem_addr_o,
    input logic            mem_wr_o,
    input logic            mem_ack_i,
    input logic            cnt_we_o,
    input logic [NCH-1:0]  tc_o
);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_wr_o)));

    // R10
    wb_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i) |=> cnt_we_o);

    // R4
    tc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_o));

    // R4
    tc_with_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc_o) |-> cnt_we_o);

    // R14
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o);

endmodule

bind dma_svc_seq dma_svc_seq_chk #(.NCH(NCH), .PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_wr_o   (mem_wr_o),
    .mem_ack_i  (mem_ack_i),
    .cnt_we_o   (cnt_we_o),
    .tc_o       (tc_o)
);

// File: tb/dma_svc_seq_test.sv
module dma_svc_seq_test;

    localparam int NCH = 4;
    localparam int LW  = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              kick = 1'b0;
    logic [3:0]        mask_v = 4'hF;
    logic [3:0]        req_v = 4'h0;
    logic [31:0]       mode_v = '0;
    logic [63:0]       bcnt_v = '0;
    logic [63:0]       badr_v = '0;
    logic [27:0]       hp_v = '0;
    logic [31:0]       lp_v = '0;
    logic [4*LW-1:0]   cur_v = '0;
    logic              mem_req;
    logic [30:0]       mem_addr;
    logic              mem_wr;
    logic              mem_ack = 1'b0;
    logic              cnt_we;
    logic [1:0]        cnt_ch;
    logic [LW-1:0]     cnt_val;
    logic [3:0]        tc;
    logic              busy;

    always #2 clk = ~clk;

    dma_svc_seq uut (
        .clk(clk), .rst_n(rst_n), .kick_i(kick),
        .mask_i(mask_v), .req_i(req_v), .mode_i(mode_v),
        .base_cnt_i(bcnt_v), .base_addr_i(badr_v),
        .hpage_i(hp_v), .lpage_i(lp_v), .cur_cnt_i(cur_v),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_wr_o(mem_wr),
        .mem_ack_i(mem_ack), .cnt_we_o(cnt_we), .cnt_ch_o(cnt_ch),
        .cnt_val_o(cnt_val), .tc_o(tc), .busy_o(busy)
    );

    int nchk = 0;
    int nfail = 0;
    int lat = 0;
    int waitc = 0;
    int n_acc = 0;
    int n_we = 0;
    int tc_cnt [4];
    logic [30:0] log_addr [64];
    logic        log_wr   [64];

    task automatic check(input string rq, input longint act, input longint exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    // Memory responder, register-file model and event log
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (cnt_we) begin
                    n_we++;
                    cur_v[int'(cnt_ch)*LW +: LW] = cnt_val;
                end
                for (int i = 0; i < 4; i++) if (tc[i]) tc_cnt[i]++;
                if (mem_req) begin
                    if (waitc >= lat) begin
                        if (n_acc < 64) begin
                            log_addr[n_acc] = mem_addr;
                            log_wr[n_acc]   = mem_wr;
                        end
                        n_acc++;
                        mem_ack = 1'b1;
                        waitc = 0;
                    end else begin
                        mem_ack = 1'b0;
                        waitc++;
                    end
                end else begin
                    mem_ack = 1'b0;
                    waitc = 0;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected idle");
        report();
    end

    task automatic clear_all();
        mask_v = 4'hF; req_v = 4'h0; mode_v = '0; bcnt_v = '0;
        badr_v = '0; hp_v = '0; lp_v = '0; cur_v = '0;
        n_acc = 0; n_we = 0; lat = 0;
        for (int i = 0; i < 4; i++) tc_cnt[i] = 0;
    endtask

    task automatic set_ch(input int ch, input logic m, input logic r,
                          input logic [7:0] md, input logic [15:0] ba,
                          input logic [15:0] bc, input logic [6:0] hp,
                          input logic [7:0] lp, input logic [LW-1:0] cur);
        mask_v[ch] = m; req_v[ch] = r;
        mode_v[ch*8 +: 8]   = md;
        badr_v[ch*16 +: 16] = ba;
        bcnt_v[ch*16 +: 16] = bc;
        hp_v[ch*7 +: 7]     = hp;
        lp_v[ch*8 +: 8]     = lp;
        cur_v[ch*LW +: LW]  = cur;
    endtask

    task automatic pulse_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    task automatic run_scan();
        pulse_kick();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R14 busy in reset", busy, 0);
        check("R14 req in reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R14 busy after reset", busy, 0);
        check("R14 cnt_we after reset", cnt_we, 0);
        check("R14 tc after reset", tc, 0);
    endtask

    task automatic t_inc_write();
        clear_all();
        set_ch(1, 0, 1, 8'h04, 16'h1000, 16'd3, 7'h12, 8'h34, '0);
        run_scan();
        check("R3 byte count", n_acc, 4);
        for (int i = 0; i < 4; i++) begin
            check("R5/R6 increment address", log_addr[i], {7'h12, 8'h34, 16'h1000 + 16'(i)});
            check("R8 write flag", log_wr[i], 1);
        end
        check("R4 tc ch1", tc_cnt[1], 1);
        check("R10 write-backs", n_we, 4);
        check("R10 final count", cur_v[1*LW +: LW], 4);
    endtask

    task automatic t_dec_read();
        clear_all();
        lat = 2;
        set_ch(2, 0, 1, 8'h28, 16'h0010, 16'd2, 7'h01, 8'h02, '0);
        run_scan();
        check("R3 byte count dec", n_acc, 3);
        for (int i = 0; i < 3; i++) begin
            check("R6 decrement address", log_addr[i], {7'h01, 8'h02, 16'h0010 - 16'(i)});
            check("R8 read flag", log_wr[i], 0);
        end
        check("R4 tc ch2", tc_cnt[2], 1);
    endtask

    task automatic t_verify();
        clear_all();
        set_ch(0, 0, 1, 8'h00, 16'h2000, 16'd5, 7'h00, 8'h00, '0);
        run_scan();
        check("R7 no memory access", n_acc, 0);
        check("R7 count advanced", cur_v[0 +: LW], 6);
        check("R7 tc ch0", tc_cnt[0], 1);
    endtask

    task automatic t_ignored();
        clear_all();
        set_ch(3, 1, 1, 8'h04, 16'h0, 16'd1, 7'h0, 8'h0, '0);
        set_ch(2, 0, 0, 8'h04, 16'h0, 16'd1, 7'h0, 8'h0, '0);
        run_scan();
        check("R1 no access", n_acc, 0);
        check("R1 no write-back", n_we, 0);
        check("R1 no tc", tc_cnt[2] + tc_cnt[3], 0);
        check("R1 counts untouched", cur_v, 0);
    endtask

    task automatic t_order();
        clear_all();
        set_ch(3, 0, 1, 8'h04, 16'h0, 16'd0, 7'h03, 8'h0, '0);
        set_ch(1, 0, 1, 8'h04, 16'h0, 16'd0, 7'h01, 8'h0, '0);
        set_ch(0, 0, 1, 8'h04, 16'h0, 16'd0, 7'h00, 8'h0, '0);
        run_scan();
        check("R2 total accesses", n_acc, 3);
        check("R2 first ch0", log_addr[0][30:24], 0);
        check("R2 second ch1", log_addr[1][30:24], 1);
        check("R2 third ch3", log_addr[2][30:24], 3);
    endtask

    task automatic t_auto();
        clear_all();
        set_ch(1, 0, 1, 8'h14, 16'h0400, 16'd1, 7'h00, 8'h00, '0);
        run_scan();
        check("R9 accesses", n_acc, 2);
        check("R9 tc", tc_cnt[1], 1);
        check("R9 count reloaded to 0", cur_v[1*LW +: LW], 0);
    endtask

    task automatic t_done_entry();
        clear_all();
        set_ch(0, 0, 1, 8'h04, 16'h0, 16'd2, 7'h00, 8'h00, 17'd3);
        run_scan();
        check("R13 no access", n_acc, 0);
        check("R13 tc", tc_cnt[0], 1);
    endtask

    task automatic t_rescan();
        int ch2n;
        clear_all();
        lat = 1;
        set_ch(2, 0, 1, 8'h04, 16'h0, 16'd7, 7'h02, 8'h00, '0);
        set_ch(0, 0, 0, 8'h04, 16'h0, 16'd0, 7'h05, 8'h00, '0);
        pulse_kick();
        while (n_acc < 3) @(negedge clk);
        req_v[0] = 1'b1;
        pulse_kick();
        while (busy) @(negedge clk);
        @(negedge clk);
        ch2n = 0;
        for (int i = 0; i < 8; i++) if (log_addr[i][30:24] == 7'h02) ch2n++;
        check("R12 total accesses", n_acc, 9);
        check("R12 ch2 finished first", ch2n, 8);
        check("R12 ch0 served after rescan", log_addr[8][30:24], 7'h05);
        check("R13 ch2 re-entered complete", tc_cnt[2], 2);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) tc_cnt[i] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        t_inc_write();
        t_dec_read();
        t_verify();
        t_ignored();
        t_order();
        t_auto();
        t_done_entry();
        t_rescan();
        report();
    end

endmodule